// File: doc/BRIEF.md
# Transmit Stall Watchdog

This block watches a transmit path for a hang and drives its recovery. On each periodic tick it compares the present values of four free-running counters with the values they held at the previous tick. The four counters are transmitted frames, received pause frames, transmit start-of-packet events, and frames accepted by the upstream feeder. The frame and pause counters show that traffic is moving. When both are frozen, the start-of-packet counter and the upstream counter tell apart two cases: an idle link, and a feeder that keeps handing frames to a transmitter that never starts them.

Recovery escalates in two steps. A detected stall first removes transmit enable for one clock and then restores the software setting. Each such toggle is counted. Once the count has passed its limit, the next stall instead asks an external sequencer for a full MAC reset, and the count starts again from zero. A two-bit status code reports the outcome of the last tick. While software holds transmit disabled, the watchdog stays passive.

Top module: `tx_stall_watchdog`

## Requirements
- R1: After reset, status is 0, reset_req is 0 and tx_en_out equals tx_sw_en. All snapshots and the toggle count are zero.
- R2: On a tick where the frame count or the pause count differs from its snapshot, status becomes 0, no pulse is issued and the toggle count is cleared.
- R3: On a tick where both of those are unchanged and the start-of-packet count is nonzero, status becomes 0, no pulse is issued and the toggle count keeps its value.
- R4: On a tick where both of those are unchanged and the start-of-packet count is zero, a stall is declared only if the upstream count differs from its snapshot and the start-of-packet snapshot is zero. Otherwise status becomes 0 and the toggle count is cleared.
- R5: On a stall while the toggle count is at most TOGGLE_LIMIT (default 4), status becomes 1 and tx_en_out is low for exactly the one cycle after the tick. The toggle count is then incremented.
- R6: On a stall while the toggle count exceeds TOGGLE_LIMIT, status becomes 2 and reset_req is high for exactly the one cycle after the tick. The toggle count is cleared, so with the defaults five stalls give status 1 and the sixth gives status 2.
- R7: Every tick, whatever its outcome, loads all four snapshots with the current counter values.
- R8: While tx_sw_en is 0, ticks give status 0 and no pulse, and the toggle count is held at zero.
- R9: The status encoding is 0 for healthy, 1 for enable toggled and 2 for reset requested. Status is updated only in the cycle after a tick and otherwise holds.
- R10: reset_req and the low pulse of tx_en_out never occur together, and each occurs only in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle evaluation strobe |
| tx_sw_en | input | 1 | Transmit enable set by software |
| frame_cnt | input | FRAME_W | Transmitted-frame counter |
| pause_cnt | input | PAUSE_W | Received-pause counter |
| sop_cnt | input | SOP_W | Transmit start-of-packet counter |
| ups_cnt | input | UPS_W | Upstream accepted-frame counter |
| tx_en_out | output | 1 | Transmit enable to the MAC |
| reset_req | output | 1 | One-cycle full MAC reset request |
| status | output | 2 | Outcome code of the last tick |

## Verification
The hardest state to reach from the ports is the reset escalation. It needs more than TOGGLE_LIMIT consecutive stall ticks. On each of them the frame and pause counters stay frozen, the start-of-packet counter reads zero on that tick and on the one before, and the upstream counter moves every time. The bench builds this with directed runs that advance only the upstream counter. It also breaks a run partway with a frame change or a nonzero start-of-packet value to show that the count restarts. A long pseudo-random sweep with narrow counters then makes equal and unequal snapshots common. An arithmetic model in the bench predicts the status of every tick.

// File: rtl/txwd_pkg.sv
package txwd_pkg;

   typedef enum logic [1:0] {
      WD_HEALTHY = 2'd0,
      WD_TOGGLED = 2'd1,
      WD_RESET   = 2'd2
   } wd_status_e;

   typedef enum logic [2:0] {
      VD_DISABLED = 3'd0,
      VD_MOVING   = 3'd1,
      VD_SOP_BUSY = 3'd2,
      VD_STALL    = 3'd3,
      VD_QUIET    = 3'd4
   } wd_verdict_e;

endpackage

// File: rtl/txwd_snap.sv
module txwd_snap #(
   parameter int W          = 16,
   parameter bit TRACK_ZERO = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         capture,
   input  logic [W-1:0] cur,
   output logic         changed,
   output logic         now_zero,
   output logic         prev_zero
);

   logic [W-1:0] held_q;

   if (W < 1) begin : g_bad_width
      $error("txwd_snap: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         held_q <= '0;
      else if (capture)
         held_q <= cur;
   end

   assign changed = (cur != held_q);

   if (TRACK_ZERO) begin : g_zero
      assign now_zero  = (cur == '0);
      assign prev_zero = (held_q == '0);
   end else begin : g_nozero
      assign now_zero  = 1'b0;
      assign prev_zero = 1'b0;
   end

endmodule

// File: rtl/txwd_judge.sv
module txwd_judge
   import txwd_pkg::*;
(
   input  logic        sw_en,
   input  logic        frame_moved,
   input  logic        pause_moved,
   input  logic        sop_now_zero,
   input  logic        sop_prev_zero,
   input  logic        ups_moved,
   output wd_verdict_e verdict
);

   always_comb begin
      if (!sw_en)
         verdict = VD_DISABLED;
      else if (frame_moved || pause_moved)
         verdict = VD_MOVING;
      else if (!sop_now_zero)
         verdict = VD_SOP_BUSY;
      else if (ups_moved && sop_prev_zero)
         verdict = VD_STALL;
      else
         verdict = VD_QUIET;
   end

endmodule

// File: rtl/txwd_escalate.sv
module txwd_escalate
   import txwd_pkg::*;
#(
   parameter int TOGGLE_LIMIT = 4,
   localparam int CW = $clog2(TOGGLE_LIMIT + 2)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          sw_en,
   input  wd_verdict_e   verdict,
   output wd_status_e    status,
   output logic          toggle_pulse,
   output logic          reset_pulse,
   output logic [CW-1:0] count
);

   localparam logic [CW-1:0] LIMIT_V = CW'(TOGGLE_LIMIT);

   if (TOGGLE_LIMIT < 0) begin : g_bad_limit
      $error("txwd_escalate: TOGGLE_LIMIT must not be negative");
   end

   wd_status_e    status_q;
   logic          toggle_q;
   logic          reset_q;
   logic [CW-1:0] count_q;
   logic          may_toggle;

   assign may_toggle = (count_q <= LIMIT_V);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= WD_HEALTHY;
         toggle_q <= 1'b0;
         reset_q  <= 1'b0;
         count_q  <= '0;
      end else begin
         toggle_q <= 1'b0;
         reset_q  <= 1'b0;
         if (!sw_en)
            count_q <= '0;
         if (tick) begin
            unique case (verdict)
               VD_STALL: begin
                  if (may_toggle) begin
                     status_q <= WD_TOGGLED;
                     toggle_q <= 1'b1;
                     count_q  <= count_q + 1'b1;
                  end else begin
                     status_q <= WD_RESET;
                     reset_q  <= 1'b1;
                     count_q  <= '0;
                  end
               end
               VD_SOP_BUSY: status_q <= WD_HEALTHY;
               default: begin
                  status_q <= WD_HEALTHY;
                  count_q  <= '0;
               end
            endcase
         end
      end
   end

   assign status       = status_q;
   assign toggle_pulse = toggle_q;
   assign reset_pulse  = reset_q;
   assign count        = count_q;

endmodule

// File: rtl/tx_stall_watchdog.sv
module tx_stall_watchdog
   import txwd_pkg::*;
#(
   parameter int FRAME_W      = 32,
   parameter int PAUSE_W      = 32,
   parameter int SOP_W        = 16,
   parameter int UPS_W        = 16,
   parameter int TOGGLE_LIMIT = 4,
   localparam int CW = $clog2(TOGGLE_LIMIT + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               tx_sw_en,
   input  logic [FRAME_W-1:0] frame_cnt,
   input  logic [PAUSE_W-1:0] pause_cnt,
   input  logic [SOP_W-1:0]   sop_cnt,
   input  logic [UPS_W-1:0]   ups_cnt,
   output logic               tx_en_out,
   output logic               reset_req,
   output logic [1:0]         status
);

   logic frame_moved, pause_moved, sop_moved, ups_moved;
   logic sop_now_zero, sop_prev_zero;
   logic unused_a, unused_b, unused_c, unused_d, unused_e, unused_f;
   logic toggle_pulse;
   logic [CW-1:0] esc_cnt;
   wd_verdict_e verdict;
   wd_status_e  stat_e;

   txwd_snap #(.W(FRAME_W), .TRACK_ZERO(1'b0)) u_frame (
      .clk(clk), .rst_n(rst_n), .capture(tick), .cur(frame_cnt),
      .changed(frame_moved), .now_zero(unused_a), .prev_zero(unused_b));

   txwd_snap #(.W(PAUSE_W), .TRACK_ZERO(1'b0)) u_pause (
      .clk(clk), .rst_n(rst_n), .capture(tick), .cur(pause_cnt),
      .changed(pause_moved), .now_zero(unused_c), .prev_zero(unused_d));

   txwd_snap #(.W(SOP_W), .TRACK_ZERO(1'b1)) u_sop (
      .clk(clk), .rst_n(rst_n), .capture(tick), .cur(sop_cnt),
      .changed(sop_moved), .now_zero(sop_now_zero), .prev_zero(sop_prev_zero));

   txwd_snap #(.W(UPS_W), .TRACK_ZERO(1'b0)) u_ups (
      .clk(clk), .rst_n(rst_n), .capture(tick), .cur(ups_cnt),
      .changed(ups_moved), .now_zero(unused_e), .prev_zero(unused_f));

   txwd_judge u_judge (
      .sw_en(tx_sw_en), .frame_moved(frame_moved), .pause_moved(pause_moved),
      .sop_now_zero(sop_now_zero), .sop_prev_zero(sop_prev_zero),
      .ups_moved(ups_moved), .verdict(verdict));

   txwd_escalate #(.TOGGLE_LIMIT(TOGGLE_LIMIT)) u_esc (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sw_en(tx_sw_en),
      .verdict(verdict), .status(stat_e), .toggle_pulse(toggle_pulse),
      .reset_pulse(reset_req), .count(esc_cnt));

   assign tx_en_out = tx_sw_en & ~toggle_pulse;
   assign status    = stat_e;

   logic unused_ok;
   assign unused_ok = &{1'b0, sop_moved, unused_a, unused_b, unused_c,
                        unused_d, unused_e, unused_f};

endmodule

// File: rtl/tx_stall_watchdog_chk.sv
module tx_stall_watchdog_chk #(
   parameter int TOGGLE_LIMIT = 4,
   parameter int CW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick,
   input logic          tx_sw_en,
   input logic          tx_en_out,
   input logic          reset_req,
   input logic [1:0]    status,
   input logic [CW-1:0] esc_cnt
);

   logic pulsed_low;
   assign pulsed_low = tx_sw_en && !tx_en_out;

   p_reset_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> status == 2'd2);

   p_reset_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_req && !tick) |=> !reset_req);

   p_toggle_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pulsed_low |-> status == 2'd1);

   p_toggle_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pulsed_low && !tick) |=> !(tx_sw_en && !tx_en_out));

   p_pulse_after_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_req || pulsed_low) |-> $past(tick));

   p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(reset_req && pulsed_low));

   p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> $stable(status));

   p_status_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      status != 2'd3);

   p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tick) && !$past(tx_sw_en)) |-> (status == 2'd0 && !reset_req));

   p_cnt_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_sw_en |=> esc_cnt == '0);

   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      esc_cnt <= CW'(TOGGLE_LIMIT + 1));

endmodule

bind tx_stall_watchdog tx_stall_watchdog_chk #(
   .TOGGLE_LIMIT(TOGGLE_LIMIT), .CW(CW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .tx_sw_en(tx_sw_en),
   .tx_en_out(tx_en_out), .reset_req(reset_req), .status(status),
   .esc_cnt(esc_cnt)
);

// File: tb/tx_stall_watchdog_bench.sv
module tx_stall_watchdog_bench;

   localparam int CLK_PERIOD = 10;
   localparam int W = 3;
   localparam int LIM = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic         tx_sw_en = 1'b1;
   logic [W-1:0] frame_cnt = '0, pause_cnt = '0, sop_cnt = '0, ups_cnt = '0;
   logic         tx_en_out, reset_req;
   logic [1:0]   status;

   int checks = 0;
   int fails = 0;

   int m_cnt = 0;
   logic [W-1:0] s_f = '0, s_p = '0, s_s = '0, s_u = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tx_stall_watchdog #(.FRAME_W(W), .PAUSE_W(W), .SOP_W(W), .UPS_W(W),
                       .TOGGLE_LIMIT(LIM)) u_tx_stall_watchdog (
      .clk(clk), .rst_n(rst_n), .tick(tick), .tx_sw_en(tx_sw_en),
      .frame_cnt(frame_cnt), .pause_cnt(pause_cnt), .sop_cnt(sop_cnt),
      .ups_cnt(ups_cnt), .tx_en_out(tx_en_out), .reset_req(reset_req),
      .status(status));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One tick with given counter values; model predicts the result.
   task automatic do_tick(input logic en, input logic [W-1:0] f, input logic [W-1:0] p,
                          input logic [W-1:0] s, input logic [W-1:0] u, input string req);
      int st;
      @(negedge clk);
      tx_sw_en = en; frame_cnt = f; pause_cnt = p; sop_cnt = s; ups_cnt = u;
      tick = 1'b1;
      if (!en) begin st = 0; m_cnt = 0; end
      else if (f != s_f || p != s_p) begin st = 0; m_cnt = 0; end
      else if (s != 0) st = 0;
      else if (u != s_u && s_s == 0) begin
         if (m_cnt <= LIM) begin st = 1; m_cnt++; end
         else begin st = 2; m_cnt = 0; end
      end else begin st = 0; m_cnt = 0; end
      s_f = f; s_p = p; s_s = s; s_u = u;   // R7 snapshot model
      @(negedge clk);
      tick = 1'b0;
      check({req, " status"}, int'(status), st);
      check({req, " reset_req"}, int'(reset_req), int'(st == 2));
      check({req, " tx_en_out"}, int'(tx_en_out), int'(en && st != 1));
      @(negedge clk);
      check({req, " R5 enable restored"}, int'(tx_en_out), int'(en));
      check({req, " R6 reset dropped"}, int'(reset_req), 0);
      check({req, " R9 status held"}, int'(status), st);
   endtask

   initial begin
      int timeout = 0;
      while (timeout < 150000) begin @(posedge clk); timeout++; end
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", timeout);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [W-1:0] u;
      logic [31:0] seed;
      repeat (3) @(negedge clk);
      check("R1 status", int'(status), 0);
      check("R1 reset_req", int'(reset_req), 0);
      check("R1 tx_en_out", int'(tx_en_out), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 status after release", int'(status), 0);

      // R6 escalation: frozen frames, sop zero, upstream advancing
      u = 0;
      for (int k = 0; k < 8; k++) begin u = u + 1; do_tick(1, 0, 0, 0, u, "R6 escalate"); end
      // R2 frame change clears count mid run
      for (int k = 0; k < 3; k++) begin u = u + 1; do_tick(1, 0, 0, 0, u, "R5 run"); end
      do_tick(1, 1, 0, 0, u, "R2 frame moved");
      for (int k = 0; k < 6; k++) begin u = u + 1; do_tick(1, 1, 0, 0, u, "R2 restart"); end
      // R2 pause change
      for (int k = 0; k < 2; k++) begin u = u + 1; do_tick(1, 1, 0, 0, u, "R5 run"); end
      do_tick(1, 1, 3, 0, u + 1, "R2 pause moved");
      u = u + 1;
      // R3 sop nonzero keeps count, R4 next tick with nonzero snapshot is no stall
      for (int k = 0; k < 3; k++) begin u = u + 1; do_tick(1, 1, 3, 0, u, "R5 run"); end
      do_tick(1, 1, 3, 2, u + 1, "R3 sop busy");
      u = u + 1;
      do_tick(1, 1, 3, 0, u + 1, "R4 prior sop nonzero");
      u = u + 1;
      do_tick(1, 1, 3, 0, u, "R4 upstream frozen");
      // R8 disabled
      for (int k = 0; k < 3; k++) begin u = u + 1; do_tick(1, 1, 3, 0, u, "R5 run"); end
      for (int k = 0; k < 3; k++) begin u = u + 1; do_tick(0, 1, 3, 0, u, "R8 disabled"); end
      for (int k = 0; k < 6; k++) begin u = u + 1; do_tick(1, 1, 3, 0, u, "R8 count was zero"); end

      // Near-exhaustive pseudo-random sweep, R7 snapshots via model
      seed = 32'h1234_5678;
      for (int i = 0; i < 3000; i++) begin
         logic [W-1:0] f, p, s, uu;
         logic en;
         seed = seed * 32'd1103515245 + 32'd12345;
         f  = (seed[18:16] == 0) ? s_f + 1 : s_f;
         p  = (seed[21:19] == 0) ? s_p + 1 : s_p;
         s  = (seed[24:22] < 2) ? W'(seed[27:25]) : '0;
         uu = seed[28] ? s_u + 1 : s_u;
         en = (seed[31:29] != 0);
         do_tick(en, f, p, s, uu, "R7 sweep");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule